// File: doc/BRIEF.md
# Byte-Lane Write Enable Decoder

This block sits between the synchronous control pins of a wide memory and its storage array. On every rising clock edge it samples a global-write control, a byte-write enable, one byte-select per lane and a processor address strobe. All of these are active low. From them it works out which byte lanes of the word are to be written in that cycle. The resulting per-lane write strobes, a read/write indication and the lane data are kept in registers. The array write therefore finishes inside the block, with no further timing from outside.

Each lane carries eight data bits. When the parity option is on, a ninth bit is added, so a 4-lane word is 36 bits wide; with the option off it is 32 bits. Global write has the highest priority. It writes every lane, whatever the byte-write enable and the lane selects are. The byte-write enable must be low for the individual lane selects to take effect. In a cycle where the processor address strobe loads a new address, the write controls are not honoured.

Top module: `lane_wr_decoder`

## Requirements
- R1: While rstN is low, laneWe, isWrite and laneData are all zero.
- R2: With addrStrobeN high and globalWrN low at an edge, every bit of laneWe is 1 after that edge, whatever byteWrEnN and laneSelN are.
- R3: With addrStrobeN high, globalWrN high and byteWrEnN low, laneWe after the edge equals the bitwise inverse of laneSelN: a select bit of 0 writes lane i, and a select bit of 1 leaves lane i read-only.
- R4: With globalWrN high and byteWrEnN high, the cycle is a read: laneWe is all zero after the edge, whatever laneSelN is.
- R5: isWrite is 1 exactly when at least one bit of laneWe is 1.
- R6: In a cycle where addrStrobeN is low at the edge, the write controls are ignored. laneWe is all zero and laneData is unchanged after that edge.
- R7: Lane i of laneData, bits [i*LB +: LB], takes the same slice of wrDataIn only at an edge that strobes lane i. Every other lane keeps its stored value.
- R8: LB is 9 when PARITY_EN is 1, so the top bit of each lane is that lane's parity bit and follows the same strobe. LB is 8 when PARITY_EN is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| globalWrN | input | 1 | Global write, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneSelN | input | LANES | Per-lane byte select, active low |
| addrStrobeN | input | 1 | Processor address strobe, active low |
| wrDataIn | input | LANES*LB | Write data for all lanes |
| laneWe | output | LANES | Registered per-lane write strobes |
| isWrite | output | 1 | Registered write (1) / read (0) indication |
| laneData | output | LANES*LB | Registered lane data held for the array write |

## Verification
The bench builds the block with four lanes and PARITY_EN set to 1, which gives 9-bit lanes and a 36-bit word. With these values every subset of lane selects can be reached. They also make the parity bit of each lane observable, so a slice or width error at a lane boundary shows up as a wrong top bit. Random control combinations let global write, byte write, read and strobe-load cycles follow one another in any order. This exercises holding of unwritten lanes across long runs of mixed traffic.

// File: rtl/lane_wr_pkg.sv
package lane_wr_pkg;
  parameter int unsigned LANE_COUNT = 4;

  typedef struct packed {
    logic [LANE_COUNT-1:0] laneEn;
    logic                  anyWrite;
  } laneCtrl_t;
endpackage

// File: rtl/lane_wr_ctrl.sv
module lane_wr_ctrl
  import lane_wr_pkg::*;
(
  input  logic                  globalWrN,
  input  logic                  byteWrEnN,
  input  logic [LANE_COUNT-1:0] laneSelN,
  input  logic                  addrStrobeN,
  output laneCtrl_t             ctrl
);
  logic [LANE_COUNT-1:0] laneEnC;

  // Priority: a strobe-load cycle blocks writes, then global write, then byte write.
  always_comb begin
    laneEnC = '0;
    if (addrStrobeN) begin
      if (!globalWrN)      laneEnC = '1;
      else if (!byteWrEnN) laneEnC = ~laneSelN;
    end
  end

  assign ctrl.laneEn   = laneEnC;
  assign ctrl.anyWrite = |laneEnC;
endmodule

// File: rtl/lane_wr_datapath.sv
module lane_wr_datapath
  import lane_wr_pkg::*;
#(
  parameter int unsigned LANE_BITS = 9
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  laneCtrl_t                       ctrl,
  input  logic [LANE_COUNT*LANE_BITS-1:0] wrDataIn,
  output logic [LANE_COUNT-1:0]           laneWe,
  output logic                            isWrite,
  output logic [LANE_COUNT*LANE_BITS-1:0] laneData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneWe  <= '0;
      isWrite <= 1'b0;
    end else begin
      laneWe  <= ctrl.laneEn;
      isWrite <= ctrl.anyWrite;
    end
  end

  for (genvar i = 0; i < LANE_COUNT; i++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               laneData[i*LANE_BITS +: LANE_BITS] <= '0;
      else if (ctrl.laneEn[i]) laneData[i*LANE_BITS +: LANE_BITS] <= wrDataIn[i*LANE_BITS +: LANE_BITS];
    end

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !laneWe[i] |-> $stable(laneData[i*LANE_BITS +: LANE_BITS])); // R7
  end

  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    isWrite == (|laneWe)); // R5
endmodule

// File: rtl/lane_wr_decoder.sv
module lane_wr_decoder
  import lane_wr_pkg::*;
#(
  parameter int unsigned PARITY_EN = 1,
  localparam int unsigned LANES    = LANE_COUNT,
  localparam int unsigned LB       = 8 + PARITY_EN,
  localparam int unsigned WORD     = LANES * LB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] laneSelN,
  input  logic             addrStrobeN,
  input  logic [WORD-1:0]  wrDataIn,
  output logic [LANES-1:0] laneWe,
  output logic             isWrite,
  output logic [WORD-1:0]  laneData
);
  laneCtrl_t ctrl;

  lane_wr_ctrl uCtrl (
    .globalWrN   (globalWrN),
    .byteWrEnN   (byteWrEnN),
    .laneSelN    (laneSelN),
    .addrStrobeN (addrStrobeN),
    .ctrl        (ctrl)
  );

  lane_wr_datapath #(.LANE_BITS(LB)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wrDataIn (wrDataIn),
    .laneWe   (laneWe),
    .isWrite  (isWrite),
    .laneData (laneData)
  );

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(addrStrobeN) && !$past(globalWrN)) |-> (&laneWe)); // R2
  AST_BYTE_MAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(addrStrobeN) && $past(globalWrN) && !$past(byteWrEnN))
      |-> (laneWe == ~$past(laneSelN))); // R3
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(globalWrN) && $past(byteWrEnN)) |-> (laneWe == '0)); // R4
  AST_STROBE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(addrStrobeN)) |-> (laneWe == '0 && $stable(laneData))); // R6
endmodule

// File: tb/lane_wr_decoder_test.sv
module lane_wr_decoder_test;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LB     = 9;
  localparam int unsigned WORD   = LANES * LB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalWrN = 1'b1, byteWrEnN = 1'b1, addrStrobeN = 1'b1;
  logic [LANES-1:0] laneSelN = '1;
  logic [WORD-1:0]  wrDataIn = '0;
  logic [LANES-1:0] laneWe;
  logic             isWrite;
  logic [WORD-1:0]  laneData;

  int checks = 0;
  int errors = 0;
  logic [WORD-1:0] expData = '0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lane_wr_decoder #(.PARITY_EN(1)) uut (
    .clk(clk), .rstN(rstN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneSelN(laneSelN), .addrStrobeN(addrStrobeN), .wrDataIn(wrDataIn),
    .laneWe(laneWe), .isWrite(isWrite), .laneData(laneData)
  );

  function automatic logic [LANES-1:0] modelLanes(logic gw, logic bwe, logic [LANES-1:0] sel, logic ps);
    if (!ps)  return '0;
    if (!gw)  return '1;
    if (!bwe) return ~sel;
    return '0;
  endfunction

  function automatic string tagOf(logic gw, logic bwe, logic ps);
    if (!ps)  return "R6";
    if (!gw)  return "R2";
    if (!bwe) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, logic [WORD-1:0] act, logic [WORD-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic gw, logic bwe, logic [LANES-1:0] sel, logic ps, logic [WORD-1:0] d);
    logic [LANES-1:0] expWe;
    globalWrN = gw; byteWrEnN = bwe; laneSelN = sel; addrStrobeN = ps; wrDataIn = d;
    expWe = modelLanes(gw, bwe, sel, ps);
    for (int i = 0; i < LANES; i++)
      if (expWe[i]) expData[i*LB +: LB] = d[i*LB +: LB];
    @(negedge clk);
    check(tagOf(gw, bwe, ps), WORD'(laneWe), WORD'(expWe));
    check("R5", WORD'(isWrite), WORD'(|expWe));
    check("R7 R8", laneData, expData);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    globalWrN = 1'b0; byteWrEnN = 1'b0; laneSelN = '0; wrDataIn = '1;
    repeat (3) @(negedge clk);
    check("R1", WORD'(laneWe), '0);
    check("R1", WORD'(isWrite), '0);
    check("R1", laneData, '0);
    rstN = 1'b1;
    // R2: global write with byte enable off and every select high
    step(1'b0, 1'b1, 4'hF, 1'b1, {4{9'h1A5}});
    // R3 and R8: write lanes 0 and 2, parity bits set
    step(1'b1, 1'b0, 4'b1010, 1'b1, {4{9'h100}});
    // R3: byte enable low but no lane selected
    step(1'b1, 1'b0, 4'hF, 1'b1, {4{9'h0FF}});
    // R4: read with all selects low
    step(1'b1, 1'b1, 4'h0, 1'b1, {4{9'h033}});
    // R6: strobe-load cycle carrying a global write
    step(1'b0, 1'b0, 4'h0, 1'b0, {4{9'h077}});
    // R3: single lane at the top boundary
    step(1'b1, 1'b0, 4'b0111, 1'b1, {4{9'h1FF}});
    for (int n = 0; n < 600; n++) begin
      logic [WORD-1:0] d;
      d = {$urandom, $urandom};
      step(1'($urandom % 3 == 0), 1'($urandom), 4'($urandom), 1'($urandom % 5 != 0), d);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule